// File: doc/BRIEF.md
# Serial Converter Command Decoder

This block is the device-side serial port of a multi-channel data converter. A host opens a frame by pulling the active-low select low. It then clocks sixteen bits in on the data input, most significant bit first, and reads sixteen bits back on the data output in the same frame. The first four bits received form an opcode. The opcode decides what the block does with the frame: start a conversion on an input channel or on an internal test level, load the 12-bit configuration word, take the oldest result from a small result queue, enter software power-down, or restore the default configuration.

The conversion engine is not part of this block. A select command raises a one-cycle start strobe and presents a selection code. The engine returns results through a push port into a four-entry queue. The word shifted out in each frame is taken from the head of that queue when the frame opens.

The serial pins are oversampled by the block clock. Each pin passes through a two-stage synchronizer and an edge detector. An internal frame state machine has four states. ST_IDLE waits for select to fall. ST_CMD counts the four opcode clocks. ST_DATA counts the twelve payload clocks. ST_DONE holds after the sixteenth clock until select rises. The transitions are:

- ST_IDLE to ST_CMD on a select fall.
- ST_CMD to ST_DATA on the fourth serial-clock fall.
- ST_DATA to ST_DONE on the sixteenth fall.
- Any of ST_CMD, ST_DATA or ST_DONE back to ST_IDLE on a select rise.

Top module: `adc_serial_ctrl`

## Requirements
- R1: After reset, sdo_oe is 0, cfg_word is 800h, pwr_down is 0, fifo_empty is 1 and conv_start is 0.
- R2: A frame opens when cs_n falls. sdi is taken on each sclk rise, and sdo advances after each sclk fall, most significant bit first. Each pin change takes effect at the third clk edge after it. sdo_oe is 1 while the frame is open.
- R3: The opcode is the first four bits received. With 8 channels, 0h–7h select channels 0–7. (With 4 channels, 4h–7h select channels 0–3.) 8h is power-down and 9h is reserved. Ah writes configuration. Bh, Ch and Dh select test levels. Eh reads the queue. Fh restores the default.
- R4: A select opcode gives exactly one conv_start pulse of one clk cycle. conv_sel holds the channel index, or holds Bh, Ch or Dh for a test level. A select frame shows the queue head on sdo but does not remove it.
- R5: A complete Ah frame loads its last 12 bits into cfg_word and empties the queue. No other opcode except Fh changes cfg_word.
- R6: Opcode Fh sets cfg_word to 800h.
- R7: An Eh frame shifts out the oldest result in bits 15..2, with bits 1..0 at zero, and removes that result when the frame ends. With an empty queue, the word is all zero.
- R8: A frame ends at the sixteenth sclk fall or at the cs_n rise, whichever comes first. sdo_oe then drops to 0, and further sclk and sdi activity is ignored until the next frame.
- R9: sclk may pause for any length of time mid-frame while cs_n stays low. The frame continues correctly when sclk resumes.
- R10: A frame cut short after at least four bits executes its opcode when cs_n rises, except that an Ah write does not load cfg_word. A frame cut short before four bits does nothing.
- R11: Opcode 8h sets pwr_down and leaves cfg_word unchanged. Opcode 9h leaves pwr_down unchanged. Any other decoded opcode clears pwr_down.
- R12: The queue holds 4 results. fifo_empty is 1 exactly when it holds none. A push into a full queue discards the oldest entry.
- R13: A push in the same cycle as the clear from an Ah frame is kept as the only entry. A push in the same cycle as an Eh removal on a full queue keeps 4 entries in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, idles low |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host, 0 when not driven |
| sdo_oe | output | 1 | Output enable for the sdo pad driver |
| cfg_word | output | 12 | Configuration register |
| pwr_down | output | 1 | Software power-down state |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_sel | output | 4 | Channel index or test-level code of the last start |
| res_push | input | 1 | Result valid from the conversion engine |
| res_data | input | 14 | Conversion result |
| fifo_empty | output | 1 | Result queue holds no entry |

## Verification
Two actions can fall in the same clock cycle: a result push from the conversion engine, and the end-of-frame action of the serial port, which either clears the queue or removes its head. The bench provokes this by raising res_push for exactly the cycle in which the sixteenth serial-clock fall is acted on. That cycle is the third clk edge after sclk drops. The bench judges the outcome by draining the queue through later read frames. After an Ah frame, only the pushed value must remain. After an Eh frame on a full queue, the remaining three old entries must come out in order, followed by the new one.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_DONE
    } frame_st_e;

    localparam logic [3:0] OP_PWRDN = 4'h8;
    localparam logic [3:0] OP_RSVD  = 4'h9;
    localparam logic [3:0] OP_WRCFG = 4'hA;
    localparam logic [3:0] OP_TMID  = 4'hB;
    localparam logic [3:0] OP_TLO   = 4'hC;
    localparam logic [3:0] OP_THI   = 4'hD;
    localparam logic [3:0] OP_FREAD = 4'hE;
    localparam logic [3:0] OP_HWDEF = 4'hF;

endpackage

// File: rtl/adc_frame_rx.sv
module adc_frame_rx
    import adc_ser_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int CMD_W   = 4,
    localparam int PAY_W  = FRAME_W - CMD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               sdi,
    input  logic [FRAME_W-1:0] load_word,
    output logic               sdo,
    output logic               sdo_oe,
    output logic               fire,
    output logic               fire_full,
    output logic [CMD_W-1:0]   fire_cmd,
    output logic [PAY_W-1:0]   payload
);

    localparam int CW = $clog2(FRAME_W + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(FRAME_W - 1);
    localparam logic [CW-1:0] CMD_CNT  = CW'(CMD_W - 1);
    localparam logic [CW-1:0] MAX_CNT  = CW'(FRAME_W);

    logic [1:0] cs_sy, sclk_sy, sdi_sy;
    logic       cs_d, sclk_d;
    logic       cs_now, cs_fall, cs_rise, sc_rise, sc_fall;
    logic       last_bit, cmd_bit, in_frame;

    frame_st_e          state_q, state_d;
    logic [CW-1:0]      cnt_q;
    logic [FRAME_W-1:0] sh_in_q, out_sh_q;
    logic [CMD_W-1:0]   cmd_q;

    // pin synchronizers and edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_sy   <= '1;
            cs_d    <= 1'b1;
            sclk_sy <= '0;
            sclk_d  <= 1'b0;
            sdi_sy  <= '0;
        end else begin
            cs_sy   <= {cs_sy[0], cs_n};
            cs_d    <= cs_sy[1];
            sclk_sy <= {sclk_sy[0], sclk};
            sclk_d  <= sclk_sy[1];
            sdi_sy  <= {sdi_sy[0], sdi};
        end
    end

    assign cs_now   = cs_sy[1];
    assign cs_fall  = cs_d & ~cs_now;
    assign cs_rise  = ~cs_d & cs_now;
    assign sc_rise  = ~sclk_d & sclk_sy[1];
    assign sc_fall  = sclk_d & ~sclk_sy[1];
    assign last_bit = (cnt_q == LAST_CNT);
    assign cmd_bit  = (cnt_q == CMD_CNT);
    assign in_frame = (state_q == ST_CMD) || (state_q == ST_DATA);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cs_fall) state_d = ST_CMD;
            ST_CMD: begin
                if (cs_rise)                 state_d = ST_IDLE;
                else if (sc_fall && cmd_bit) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (cs_rise)                  state_d = ST_IDLE;
                else if (sc_fall && last_bit) state_d = ST_DONE;
            end
            ST_DONE: if (cs_rise) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift registers and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sh_in_q  <= '0;
            out_sh_q <= '0;
            cmd_q    <= '0;
        end else if (state_q == ST_IDLE && cs_fall) begin
            cnt_q    <= '0;
            sh_in_q  <= '0;
            out_sh_q <= load_word;
        end else if (in_frame && !cs_rise) begin
            if (sc_rise) sh_in_q <= {sh_in_q[FRAME_W-2:0], sdi_sy[1]};
            if (sc_fall) begin
                cnt_q    <= cnt_q + 1'b1;
                out_sh_q <= {out_sh_q[FRAME_W-2:0], 1'b0};
                if (state_q == ST_CMD && cmd_bit) cmd_q <= sh_in_q[CMD_W-1:0];
            end
        end
    end

    // outputs
    always_comb begin
        sdo_oe    = in_frame;
        sdo       = in_frame ? out_sh_q[FRAME_W-1] : 1'b0;
        fire_full = (state_q == ST_DATA) && !cs_rise && sc_fall && last_bit;
        fire      = (state_q == ST_DATA) && (cs_rise || (sc_fall && last_bit));
        fire_cmd  = fire_full ? sh_in_q[FRAME_W-1 -: CMD_W] : cmd_q;
        payload   = sh_in_q[PAY_W-1:0];
    end

    AST_OE_OFF_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_now && cs_d) |-> !sdo_oe);  // R8
    AST_OE_OFF_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        fire_full |=> !sdo_oe);  // R8
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= MAX_CNT);  // R8
    AST_FIRE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (cs_rise || sc_fall));  // R10

endmodule

// File: rtl/adc_cmd_exec.sv
module adc_cmd_exec
    import adc_ser_pkg::*;
#(
    parameter int CFG_W                   = 12,
    parameter int NUM_CH                  = 8,
    parameter logic [CFG_W-1:0] CFG_RESET = 12'h800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             fire_full,
    input  logic [3:0]       fire_cmd,
    input  logic [CFG_W-1:0] payload,
    output logic [CFG_W-1:0] cfg_word,
    output logic             pwr_down,
    output logic             conv_start,
    output logic [3:0]       conv_sel,
    output logic             fifo_pop,
    output logic             fifo_clr
);

    logic       is_chan, is_test, is_sel, exits_pd;
    logic [2:0] chan_idx;
    logic [3:0] sel_code;

    generate
        if (NUM_CH == 8) begin : g_ch8
            assign is_chan  = ~fire_cmd[3];
            assign chan_idx = fire_cmd[2:0];
        end else begin : g_ch4
            assign is_chan  = (fire_cmd[3:2] == 2'b01);
            assign chan_idx = {1'b0, fire_cmd[1:0]};
        end
    endgenerate

    assign is_test  = (fire_cmd == OP_TMID) || (fire_cmd == OP_TLO) || (fire_cmd == OP_THI);
    assign is_sel   = is_chan || is_test;
    assign sel_code = is_chan ? {1'b0, chan_idx} : fire_cmd;
    assign exits_pd = is_sel || (fire_cmd == OP_WRCFG) || (fire_cmd == OP_FREAD)
                    || (fire_cmd == OP_HWDEF);
    assign fifo_clr = fire && fire_full && (fire_cmd == OP_WRCFG);
    assign fifo_pop = fire && (fire_cmd == OP_FREAD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_word   <= CFG_RESET;
            pwr_down   <= 1'b0;
            conv_start <= 1'b0;
            conv_sel   <= '0;
        end else begin
            conv_start <= fire && is_sel;
            if (fire && is_sel) conv_sel <= sel_code;
            if (fire) begin
                if (fire_cmd == OP_PWRDN) pwr_down <= 1'b1;
                else if (exits_pd)        pwr_down <= 1'b0;
                if (fire_full && fire_cmd == OP_WRCFG) cfg_word <= payload;
                else if (fire_cmd == OP_HWDEF)         cfg_word <= CFG_RESET;
            end
        end
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);  // R4
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(cfg_word));  // R5
    AST_PD_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && fire_cmd == OP_PWRDN) |=> (pwr_down && $stable(cfg_word)));  // R11

endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo #(
    parameter int RES_W = 14,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [RES_W-1:0] push_data,
    input  logic             pop,
    input  logic             clr,
    output logic [RES_W-1:0] head,
    output logic             empty
);

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW + 1)'(DEPTH);

    logic [RES_W-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_q, wr_ptr;
    logic [AW:0]      cnt_q;
    logic             full, drop, take;

    assign full   = (cnt_q == FULL_CNT);
    assign empty  = (cnt_q == '0);
    assign drop   = push && full && !pop;
    assign take   = (pop && !empty) || drop;
    assign wr_ptr = rd_q + cnt_q[AW-1:0];
    assign head   = empty ? '0 : mem[rd_q];

    always_ff @(posedge clk) begin
        if (clr) begin
            if (push) mem[0] <= push_data;
        end else if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            rd_q  <= '0;
            cnt_q <= push ? (AW + 1)'(1) : '0;
        end else begin
            rd_q  <= rd_q + AW'(take);
            cnt_q <= cnt_q + (AW + 1)'(push) - (AW + 1)'(take);
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);  // R12
    AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !clr) |=> full);  // R12
    AST_CLR_KEEPS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && push) |=> (cnt_q == (AW + 1)'(1) && head == $past(push_data)));  // R13

endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl #(
    parameter int FRAME_W                = 16,
    parameter int RES_W                  = 14,
    parameter int FIFO_DEPTH             = 4,
    parameter int NUM_CH                 = 8,
    parameter logic [11:0] CFG_RESET     = 12'h800,
    localparam int CMD_W                 = 4,
    localparam int CFG_W                 = FRAME_W - CMD_W,
    localparam int PAD_W                 = FRAME_W - RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             sdi,
    output logic             sdo,
    output logic             sdo_oe,
    output logic [CFG_W-1:0] cfg_word,
    output logic             pwr_down,
    output logic             conv_start,
    output logic [3:0]       conv_sel,
    input  logic             res_push,
    input  logic [RES_W-1:0] res_data,
    output logic             fifo_empty
);

    logic               fire, fire_full, fifo_pop, fifo_clr;
    logic [CMD_W-1:0]   fire_cmd;
    logic [CFG_W-1:0]   payload;
    logic [RES_W-1:0]   fifo_head;
    logic [FRAME_W-1:0] load_word;

    assign load_word = {fifo_head, {PAD_W{1'b0}}};

    adc_frame_rx #(.FRAME_W(FRAME_W), .CMD_W(CMD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .load_word(load_word), .sdo(sdo), .sdo_oe(sdo_oe),
        .fire(fire), .fire_full(fire_full), .fire_cmd(fire_cmd), .payload(payload)
    );

    adc_cmd_exec #(.CFG_W(CFG_W), .NUM_CH(NUM_CH), .CFG_RESET(CFG_W'(CFG_RESET))) u_exec (
        .clk(clk), .rst_n(rst_n), .fire(fire), .fire_full(fire_full),
        .fire_cmd(fire_cmd), .payload(payload), .cfg_word(cfg_word),
        .pwr_down(pwr_down), .conv_start(conv_start), .conv_sel(conv_sel),
        .fifo_pop(fifo_pop), .fifo_clr(fifo_clr)
    );

    adc_result_fifo #(.RES_W(RES_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(res_push), .push_data(res_data),
        .pop(fifo_pop), .clr(fifo_clr), .head(fifo_head), .empty(fifo_empty)
    );

endmodule

// File: tb/tb_adc_serial_ctrl.sv
`timescale 1ns/1ps
module tb_adc_serial_ctrl;

    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
    logic        sdo, sdo_oe, pwr_down, conv_start, fifo_empty;
    logic [11:0] cfg_word;
    logic [3:0]  conv_sel;
    logic        res_push = 1'b0;
    logic [13:0] res_data = '0;

    int n_chk = 0;
    int n_err = 0;
    logic [3:0] exp_q[$];

    always #4 clk = ~clk;

    adc_serial_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .cfg_word(cfg_word), .pwr_down(pwr_down),
        .conv_start(conv_start), .conv_sel(conv_sel), .res_push(res_push),
        .res_data(res_data), .fifo_empty(fifo_empty)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: every conversion strobe must match the next expected selection (R4)
    always @(negedge clk) begin
        if (rst_n && conv_start) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_err++;
                $display("FAIL R4 unexpected start: actual=%0h expected=none", conv_sel);
            end else begin
                logic [3:0] e;
                e = exp_q.pop_front();
                if (conv_sel !== e) begin
                    n_err++;
                    $display("FAIL R4 conv_sel: actual=%0h expected=%0h", conv_sel, e);
                end
            end
        end
    end

    task automatic push_res(input logic [13:0] d);
        @(negedge clk); res_push = 1'b1; res_data = d;
        @(negedge clk); res_push = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] din, input int nbits, input int stall_at,
                         input bit push_end, input logic [13:0] pdata,
                         output logic [15:0] dout);
        dout = '0;
        @(negedge clk); cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 16) ? din[15-i] : 1'b1;
            repeat (HALF) @(negedge clk);
            if (i == 0) check("R2 sdo_oe in frame", sdo_oe, 1);
            if (i < 16) dout[15-i] = sdo;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
            if (push_end && i == 15) begin
                repeat (2) @(negedge clk);
                res_push = 1'b1; res_data = pdata;
                @(negedge clk);
                res_push = 1'b0;
                repeat (HALF - 3) @(negedge clk);
            end else begin
                repeat (HALF) @(negedge clk);
            end
            if (i == stall_at) repeat (300) @(negedge clk);
        end
        if (nbits >= 16) check("R8 sdo_oe off after bit 16", sdo_oe, 0);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        check("R8 sdo_oe off after cs_n rise", sdo_oe, 0);
    endtask

    task automatic read_res(input string tag, input logic [13:0] exp);
        logic [15:0] w;
        frame(16'hE000, 16, -1, 1'b0, '0, w);
        check(tag, w, {exp, 2'b00});
    endtask

    initial begin
        repeat (1500000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 sdo_oe", sdo_oe, 0);
        check("R1 cfg_word", cfg_word, 12'h800);
        check("R1 pwr_down", pwr_down, 0);
        check("R1 fifo_empty", fifo_empty, 1);
        check("R1 conv_start", conv_start, 0);

        // R3 R5 configuration write
        frame(16'hA5A3, 16, -1, 1'b0, '0, w);
        check("R5 cfg write", cfg_word, 12'h5A3);
        check("R7 empty queue word", w, 16'h0000);

        // R4 channel and test selects, R9 stall mid-frame
        exp_q.push_back(4'h3); frame(16'h3000, 16, -1, 1'b0, '0, w);
        exp_q.push_back(4'h6); frame(16'h6FFF, 16, 7, 1'b0, '0, w);
        exp_q.push_back(4'hB); frame(16'hB000, 16, -1, 1'b0, '0, w);
        exp_q.push_back(4'hD); frame(16'hD123, 16, -1, 1'b0, '0, w);
        check("R4 all starts seen", exp_q.size(), 0);
        check("R5 select leaves cfg", cfg_word, 12'h5A3);

        // R7 R2 queue reads, R12 empty flag
        push_res(14'h1ABC);
        push_res(14'h0123);
        check("R12 not empty", fifo_empty, 0);
        read_res("R7 first result", 14'h1ABC);
        read_res("R7 second result", 14'h0123);
        check("R12 empty after reads", fifo_empty, 1);
        read_res("R7 empty read", 14'h0);

        // R4 select shows head without removing it; R9 stall in a read
        push_res(14'h2222);
        exp_q.push_back(4'h0); frame(16'h0000, 16, -1, 1'b0, '0, w);
        check("R4 select shows head", w, 16'h8888);
        frame(16'hE000, 16, 9, 1'b0, '0, w);
        check("R9 read across stall", w, 16'h8888);

        // R6 default restore
        frame(16'hA0F0, 16, -1, 1'b0, '0, w);
        check("R5 cfg 0F0", cfg_word, 12'h0F0);
        frame(16'hF000, 16, -1, 1'b0, '0, w);
        check("R6 default", cfg_word, 12'h800);

        // R10 shortened frames
        frame(16'hAFFF, 10, -1, 1'b0, '0, w);
        check("R10 short write ignored", cfg_word, 12'h800);
        exp_q.push_back(4'h5); frame(16'h5000, 6, -1, 1'b0, '0, w);
        frame(16'h1000, 3, -1, 1'b0, '0, w);
        frame(16'h8000, 2, -1, 1'b0, '0, w);
        check("R10 short select and tiny frames", exp_q.size(), 0);
        check("R10 tiny pd ignored", pwr_down, 0);

        // R8 extra clocks after bit 16
        frame(16'hA3C3, 18, -1, 1'b0, '0, w);
        check("R8 extra clocks ignored", cfg_word, 12'h3C3);

        // R11 power-down
        frame(16'h8000, 16, -1, 1'b0, '0, w);
        check("R11 pd set", pwr_down, 1);
        check("R11 cfg kept", cfg_word, 12'h3C3);
        frame(16'h9000, 16, -1, 1'b0, '0, w);
        check("R11 reserved keeps pd", pwr_down, 1);
        exp_q.push_back(4'hC); frame(16'hC000, 16, -1, 1'b0, '0, w);
        check("R11 select exits pd", pwr_down, 0);

        // R12 overflow drops oldest
        for (int k = 1; k <= 5; k++) push_res(14'(k * 16'h111));
        read_res("R12 oldest dropped", 14'h0222);
        read_res("R12 order", 14'h0333);
        read_res("R12 order", 14'h0444);
        read_res("R12 order", 14'h0555);
        check("R12 empty", fifo_empty, 1);

        // R13 push coinciding with clear
        push_res(14'h0AAA);
        push_res(14'h0BBB);
        frame(16'hA111, 16, -1, 1'b1, 14'h3EEE, w);
        check("R5 cfg 111", cfg_word, 12'h111);
        read_res("R13 push kept over clear", 14'h3EEE);
        check("R13 only entry", fifo_empty, 1);

        // R13 push coinciding with removal on a full queue
        for (int k = 1; k <= 4; k++) push_res(14'(k * 16'h101));
        frame(16'hE000, 16, -1, 1'b1, 14'h1555, w);
        check("R13 read word", w, {14'h0101, 2'b00});
        read_res("R13 order", 14'h0202);
        read_res("R13 order", 14'h0303);
        read_res("R13 order", 14'h0404);
        read_res("R13 pushed last", 14'h1555);
        check("R13 drained", fifo_empty, 1);
        check("R4 no pending starts", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule